// File: doc/BRIEF.md
# OSD Region Hit and Inversion Selector

This block makes the per-macroblock overlay decision for an on-screen-display stage in a video encoder. Software programs up to eight rectangular overlay regions. Each region has an enable, inclusive macroblock corners, an overlay data base address and a set of colour-inversion controls. For every queried macroblock coordinate, the block picks the region that covers it. It returns the byte address of that macroblock's 256-byte overlay block. It also decides whether the luma and chroma of the overlay must be colour-inverted, because the background sample and the overlay foreground sample are too close to tell apart.

The inversion decision has two parts. Luma and chroma each get a closeness condition: the absolute sample difference is compared against the region's 4-bit threshold scaled by 16. A per-region, per-component mask bit can force a condition true. A per-region expression bit then joins the two conditions with AND or OR. Separate enable bits for luma and chroma gate the final result. Palette lookup and blending happen downstream.

Queries are presented with a valid strobe. All results appear on registered outputs one clock later. Configuration is loaded through a single-cycle write port.

Top module: `osd_region_selector`

## Requirements
- R1: After reset, every region is disabled, all inversion enables, expression bits, masks and corners are zero, and every threshold is 15. Register map by write address: 0 = region enables (bit i for region i), 1 = luma inversion enables, 2 = chroma inversion enables, 3 = expression type, 4 = luma masks, 5 = chroma masks, 6 = thresholds (region i in bits 4i+3..4i), 8+i = corners of region i (left x in bits 7:0, top y in 15:8, right x in 23:16, bottom y in 31:24), 16+i = base address of region i.
- R2: A region hits a macroblock only when its enable bit is set and left <= x <= right and top <= y <= bottom (all corners inclusive). A disabled region never hits.
- R3: When several enabled regions cover the macroblock, the lowest-numbered one is reported.
- R4: On a hit, the address is base + 256*((y - top)*(right - left + 1) + (x - left)), with the low 4 bits of the base taken as zero.
- R5: A write to a base address whose low 4 bits are non-zero sets the alignment-error output, which then stays set until reset.
- R6: A component's closeness condition is true when |background - foreground| < threshold*16 on 8-bit samples.
- R7: Expression bit 0 joins the luma and chroma conditions with AND, and 1 joins them with OR.
- R8: A set luma (chroma) mask bit makes the luma (chroma) condition true whatever the samples are.
- R9: The luma invert output is the joined condition gated by the region's luma inversion enable, and the chroma invert output is the joined condition gated by the chroma inversion enable.
- R10: Outputs are registered one cycle after the query. Without a valid query, or without a hit, the hit flag, region number, address and both invert outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration register address |
| wr_data | input | 32 | Configuration write data |
| q_valid | input | 1 | Query strobe |
| q_mbx | input | 8 | Query macroblock column |
| q_mby | input | 8 | Query macroblock row |
| q_bg_luma | input | 8 | Background luma sample |
| q_fg_luma | input | 8 | Overlay foreground luma sample |
| q_bg_chroma | input | 8 | Background chroma sample |
| q_fg_chroma | input | 8 | Overlay foreground chroma sample |
| o_valid | output | 1 | Result valid, one cycle after q_valid |
| o_hit | output | 1 | Some enabled region covers the macroblock |
| o_region | output | 3 | Winning region number |
| o_addr | output | 32 | Overlay data byte address for the macroblock |
| o_inv_luma | output | 1 | Invert overlay luma |
| o_inv_chroma | output | 1 | Invert overlay chroma |
| align_err | output | 1 | Sticky misaligned base address flag |

## Verification
Some properties are checked on every cycle. The result strobe must follow the query strobe by exactly one cycle. A miss must leave the address, region number and invert outputs at zero. Every hit address must keep 16-byte alignment. The alignment flag must never drop outside reset, and it may rise only after a misaligned base write. Only the bench scenarios can show the rest: the inclusive corner edges, the priority between overlapping regions, the exact address arithmetic, the threshold boundary (including the default of 15), the AND/OR join with masks, and the per-component enables.

// File: rtl/osd_sel_pkg.sv
package osd_sel_pkg;
  localparam int N_RGN = 8;
  localparam int CRD_W = 8;
  localparam int THR_W = 4;
  localparam int PIX_W = THR_W + 4;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int BLK_SHIFT = 8;

  localparam logic [THR_W-1:0] THR_RST = '1;

  typedef struct packed {
    logic              en;
    logic              linv;
    logic              cinv;
    logic              typ_or;
    logic              lmsk;
    logic              cmsk;
    logic [THR_W-1:0]  thr;
    logic [CRD_W-1:0]  lt_x;
    logic [CRD_W-1:0]  lt_y;
    logic [CRD_W-1:0]  rb_x;
    logic [CRD_W-1:0]  rb_y;
    logic [AW-5:0]     base_hi;
  } rgn_cfg_t;
endpackage

// File: rtl/osd_sel_regs.sv
module osd_sel_regs
  import osd_sel_pkg::*;
#(
  parameter int NUM_RGN = N_RGN,
  parameter int RA_W    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [DW-1:0]   wr_data,
  output rgn_cfg_t        cfg [NUM_RGN],
  output logic            align_err
);
  localparam logic [RA_W-1:0] A_EN   = RA_W'(0);
  localparam logic [RA_W-1:0] A_LINV = RA_W'(1);
  localparam logic [RA_W-1:0] A_CINV = RA_W'(2);
  localparam logic [RA_W-1:0] A_TYP  = RA_W'(3);
  localparam logic [RA_W-1:0] A_LMSK = RA_W'(4);
  localparam logic [RA_W-1:0] A_CMSK = RA_W'(5);
  localparam logic [RA_W-1:0] A_THR  = RA_W'(6);
  localparam int CRN_OFS = 8;
  localparam int BAS_OFS = CRN_OFS + NUM_RGN;

  rgn_cfg_t cfg_q [NUM_RGN];
  logic     err_q;
  logic     base_wr;

  always_comb begin
    base_wr = 1'b0;
    for (int i = 0; i < NUM_RGN; i++)
      if (wr_addr == RA_W'(BAS_OFS + i)) base_wr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RGN; i++) begin
        cfg_q[i]     <= '0;
        cfg_q[i].thr <= THR_RST;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NUM_RGN; i++) begin
        if (wr_addr == A_EN)   cfg_q[i].en     <= wr_data[i];
        if (wr_addr == A_LINV) cfg_q[i].linv   <= wr_data[i];
        if (wr_addr == A_CINV) cfg_q[i].cinv   <= wr_data[i];
        if (wr_addr == A_TYP)  cfg_q[i].typ_or <= wr_data[i];
        if (wr_addr == A_LMSK) cfg_q[i].lmsk   <= wr_data[i];
        if (wr_addr == A_CMSK) cfg_q[i].cmsk   <= wr_data[i];
        if (wr_addr == A_THR)  cfg_q[i].thr    <= wr_data[THR_W*i +: THR_W];
        if (wr_addr == RA_W'(CRN_OFS + i)) begin
          cfg_q[i].lt_x <= wr_data[0       +: CRD_W];
          cfg_q[i].lt_y <= wr_data[CRD_W   +: CRD_W];
          cfg_q[i].rb_x <= wr_data[2*CRD_W +: CRD_W];
          cfg_q[i].rb_y <= wr_data[3*CRD_W +: CRD_W];
        end
        if (wr_addr == RA_W'(BAS_OFS + i)) cfg_q[i].base_hi <= wr_data[AW-1:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                          err_q <= 1'b0;
    else if (wr_en && base_wr && (wr_data[3:0] != 4'h0)) err_q <= 1'b1;
  end

  assign cfg       = cfg_q;
  assign align_err = err_q;
endmodule

// File: rtl/osd_sel_pick.sv
module osd_sel_pick
  import osd_sel_pkg::*;
#(
  parameter int NUM_RGN = N_RGN,
  parameter int IDX_W   = $clog2(NUM_RGN)
) (
  input  rgn_cfg_t          cfg [NUM_RGN],
  input  logic [CRD_W-1:0]  mbx,
  input  logic [CRD_W-1:0]  mby,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [NUM_RGN-1:0] hv;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_hit
    assign hv[g] = cfg[g].en &&
                   (mbx >= cfg[g].lt_x) && (mbx <= cfg[g].rb_x) &&
                   (mby >= cfg[g].lt_y) && (mby <= cfg[g].rb_y);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/osd_sel_addr.sv
module osd_sel_addr
  import osd_sel_pkg::*;
(
  input  rgn_cfg_t          sel,
  input  logic [CRD_W-1:0]  mbx,
  input  logic [CRD_W-1:0]  mby,
  output logic [AW-1:0]     addr
);
  localparam int OFS_W = 2 * CRD_W + 1;

  logic [CRD_W-1:0] row;
  logic [CRD_W-1:0] col;
  logic [CRD_W:0]   wid;
  logic [OFS_W-1:0] blk;

  always_comb begin
    row  = mby - sel.lt_y;
    col  = mbx - sel.lt_x;
    wid  = {1'b0, sel.rb_x} - {1'b0, sel.lt_x} + (CRD_W+1)'(1);
    blk  = (OFS_W'(row) * OFS_W'(wid)) + OFS_W'(col);
    addr = {sel.base_hi, 4'h0} + (AW'(blk) << BLK_SHIFT);
  end
endmodule

// File: rtl/osd_sel_inv.sv
module osd_sel_inv
  import osd_sel_pkg::*;
(
  input  rgn_cfg_t          sel,
  input  logic [PIX_W-1:0]  bg_l,
  input  logic [PIX_W-1:0]  fg_l,
  input  logic [PIX_W-1:0]  bg_c,
  input  logic [PIX_W-1:0]  fg_c,
  output logic              inv_l,
  output logic              inv_c
);
  logic [PIX_W-1:0] d_l;
  logic [PIX_W-1:0] d_c;
  logic [PIX_W-1:0] lim;
  logic             ok_l;
  logic             ok_c;
  logic             join_ok;

  always_comb begin
    d_l     = (bg_l > fg_l) ? (bg_l - fg_l) : (fg_l - bg_l);
    d_c     = (bg_c > fg_c) ? (bg_c - fg_c) : (fg_c - bg_c);
    lim     = {sel.thr, 4'h0};
    ok_l    = sel.lmsk || (d_l < lim);
    ok_c    = sel.cmsk || (d_c < lim);
    join_ok = sel.typ_or ? (ok_l || ok_c) : (ok_l && ok_c);
    inv_l   = sel.linv && join_ok;
    inv_c   = sel.cinv && join_ok;
  end
endmodule

// File: rtl/osd_region_selector.sv
module osd_region_selector
  import osd_sel_pkg::*;
#(
  parameter  int NUM_RGN = N_RGN,
  localparam int RA_W    = $clog2(8 + 2 * NUM_RGN),
  localparam int IDX_W   = $clog2(NUM_RGN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              q_valid,
  input  logic [CRD_W-1:0]  q_mbx,
  input  logic [CRD_W-1:0]  q_mby,
  input  logic [PIX_W-1:0]  q_bg_luma,
  input  logic [PIX_W-1:0]  q_fg_luma,
  input  logic [PIX_W-1:0]  q_bg_chroma,
  input  logic [PIX_W-1:0]  q_fg_chroma,
  output logic              o_valid,
  output logic              o_hit,
  output logic [IDX_W-1:0]  o_region,
  output logic [AW-1:0]     o_addr,
  output logic              o_inv_luma,
  output logic              o_inv_chroma,
  output logic              align_err
);
  rgn_cfg_t          cfg [NUM_RGN];
  rgn_cfg_t          sel;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [AW-1:0]     addr;
  logic              inv_l;
  logic              inv_c;

  osd_sel_regs #(.NUM_RGN(NUM_RGN), .RA_W(RA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cfg       (cfg),
    .align_err (align_err)
  );

  osd_sel_pick #(.NUM_RGN(NUM_RGN), .IDX_W(IDX_W)) u_pick (
    .cfg (cfg),
    .mbx (q_mbx),
    .mby (q_mby),
    .hit (hit),
    .idx (idx)
  );

  assign sel = cfg[idx];

  osd_sel_addr u_addr (
    .sel  (sel),
    .mbx  (q_mbx),
    .mby  (q_mby),
    .addr (addr)
  );

  osd_sel_inv u_inv (
    .sel   (sel),
    .bg_l  (q_bg_luma),
    .fg_l  (q_fg_luma),
    .bg_c  (q_bg_chroma),
    .fg_c  (q_fg_chroma),
    .inv_l (inv_l),
    .inv_c (inv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid      <= 1'b0;
      o_hit        <= 1'b0;
      o_region     <= '0;
      o_addr       <= '0;
      o_inv_luma   <= 1'b0;
      o_inv_chroma <= 1'b0;
    end else begin
      o_valid      <= q_valid;
      o_hit        <= q_valid && hit;
      o_region     <= (q_valid && hit) ? idx : '0;
      o_addr       <= (q_valid && hit) ? addr : '0;
      o_inv_luma   <= q_valid && hit && inv_l;
      o_inv_chroma <= q_valid && hit && inv_c;
    end
  end
endmodule

// File: rtl/osd_sel_chk.sv
module osd_sel_chk
  import osd_sel_pkg::*;
#(
  parameter int RA_W  = 5,
  parameter int IDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [RA_W-1:0]   wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              q_valid,
  input logic              o_valid,
  input logic              o_hit,
  input logic [IDX_W-1:0]  o_region,
  input logic [AW-1:0]     o_addr,
  input logic              o_inv_luma,
  input logic              o_inv_chroma,
  input logic              align_err
);
  AST_RESULT_FOLLOWS_QUERY: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> o_valid); // R10
  AST_NO_RESULT_WITHOUT_QUERY: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> !o_valid); // R10
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    o_hit |-> o_valid); // R10
  AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !o_hit |-> (!o_inv_luma && !o_inv_chroma && o_addr == '0 && o_region == '0)); // R10
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    o_hit |-> (o_addr[3:0] == 4'h0)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    align_err |=> align_err); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(align_err) |-> $past(wr_en && wr_data[3:0] != 4'h0)); // R5
endmodule

bind osd_region_selector osd_sel_chk #(.RA_W(RA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/osd_region_selector_bench.sv
`timescale 1ns/1ps
module osd_region_selector_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic        q_valid;
  logic [7:0]  q_mbx, q_mby, q_bg_luma, q_fg_luma, q_bg_chroma, q_fg_chroma;
  logic        o_valid, o_hit, o_inv_luma, o_inv_chroma, align_err;
  logic [2:0]  o_region;
  logic [31:0] o_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  osd_region_selector u_osd_region_selector (.*);

  typedef struct packed {
    logic [7:0]  x, y, bl, fl, bc, fc;
    logic        hit;
    logic [2:0]  rgn;
    logic [31:0] addr;
    logic        il, ic;
  } vec_t;

  // fields: x, y, bg_l, fg_l, bg_c, fg_c, hit, region, addr, inv_l, inv_c
  localparam vec_t VECS [13] = '{
    '{8'd2,  8'd2,  8'd100, 8'd110, 8'd50,  8'd90,  1'b1, 3'd0, 32'h0000_1000, 1'b0, 1'b0}, // R2 R7 corner, AND fails
    '{8'd4,  8'd3,  8'd100, 8'd131, 8'd60,  8'd60,  1'b1, 3'd0, 32'h0000_1500, 1'b1, 1'b1}, // R4 R6 diff 31 < 32
    '{8'd3,  8'd3,  8'd0,   8'd32,  8'd7,   8'd7,   1'b1, 3'd0, 32'h0000_1400, 1'b0, 1'b0}, // R3 overlap, R6 diff 32
    '{8'd5,  8'd3,  8'd200, 8'd180, 8'd10,  8'd25,  1'b1, 3'd1, 32'h0002_0200, 1'b1, 1'b0}, // R7 OR, R9 chroma gated
    '{8'd6,  8'd5,  8'd0,   8'd255, 8'd0,   8'd255, 1'b1, 3'd1, 32'h0002_0B00, 1'b0, 1'b0}, // R2 R4 bottom-right
    '{8'd7,  8'd5,  8'd0,   8'd0,   8'd0,   8'd0,   1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R2 right+1
    '{8'd8,  8'd8,  8'd0,   8'd0,   8'd0,   8'd0,   1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R2 disabled
    '{8'd10, 8'd10, 8'd0,   8'd255, 8'd100, 8'd105, 1'b1, 3'd3, 32'h0004_0000, 1'b1, 1'b1}, // R8 luma masked
    '{8'd10, 8'd10, 8'd0,   8'd255, 8'd100, 8'd116, 1'b1, 3'd3, 32'h0004_0000, 1'b0, 1'b0}, // R8 chroma not met
    '{8'd23, 8'd1,  8'd0,   8'd239, 8'd0,   8'd0,   1'b1, 3'd7, 32'h0003_0700, 1'b1, 1'b1}, // R1 default thr
    '{8'd20, 8'd0,  8'd0,   8'd240, 8'd0,   8'd0,   1'b1, 3'd7, 32'h0003_0000, 1'b0, 1'b0}, // R6 240 boundary
    '{8'd2,  8'd4,  8'd0,   8'd0,   8'd0,   8'd0,   1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R2 bottom+1
    '{8'd1,  8'd2,  8'd0,   8'd0,   8'd0,   8'd0,   1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}  // R2 left-1
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic query(input vec_t v, input string req);
    @(negedge clk);
    q_valid = 1'b1; q_mbx = v.x; q_mby = v.y;
    q_bg_luma = v.bl; q_fg_luma = v.fl; q_bg_chroma = v.bc; q_fg_chroma = v.fc;
    @(negedge clk);
    q_valid = 1'b0;
    check({req, " valid"},  64'(o_valid), 64'(1'b1));
    check({req, " hit"},    64'(o_hit), 64'(v.hit));
    check({req, " region"}, 64'(o_region), 64'(v.rgn));
    check({req, " addr"},   64'(o_addr), 64'(v.addr));
    check({req, " inv_l"},  64'(o_inv_luma), 64'(v.il));
    check({req, " inv_c"},  64'(o_inv_chroma), 64'(v.ic));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; q_valid = 1'b0;
    q_mbx = '0; q_mby = '0; q_bg_luma = '0; q_fg_luma = '0; q_bg_chroma = '0; q_fg_chroma = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset valid", 64'(o_valid), 64'(0));
    check("R10 reset hit",   64'(o_hit), 64'(0));
    check("R5 reset err",    64'(align_err), 64'(0));
    // R1: no region enabled out of reset
    query('{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b0}, "R1 reset disabled");

    wr(5'd0, 32'h0000_008B);
    wr(5'd1, 32'h0000_008B);
    wr(5'd2, 32'h0000_0089);
    wr(5'd3, 32'h0000_0002);
    wr(5'd4, 32'h0000_0008);
    wr(5'd5, 32'h0000_0080);
    wr(5'd6, 32'hFFFF_1F12);
    wr(5'd8,  32'h0304_0202);
    wr(5'd9,  32'h0506_0303);
    wr(5'd10, 32'h0909_0808);
    wr(5'd11, 32'h0A0A_0A0A);
    wr(5'd15, 32'h0117_0014);
    wr(5'd16, 32'h0000_1000);
    wr(5'd17, 32'h0002_0000);
    wr(5'd19, 32'h0004_0000);
    check("R5 aligned writes no err", 64'(align_err), 64'(0));
    wr(5'd23, 32'h0003_0008);
    check("R5 misaligned sets err", 64'(align_err), 64'(1));

    for (int i = 0; i < 13; i++) query(VECS[i], $sformatf("vec%0d", i));

    // R3: disable region 0, region 1 now wins at (3,3)
    wr(5'd0, 32'h0000_008A);
    query('{8'd3, 8'd3, 8'd0, 8'd32, 8'd7, 8'd7, 1'b1, 3'd1, 32'h0002_0000, 1'b1, 1'b0}, "R3 next region");

    wr(5'd16, 32'h0000_1000);
    check("R5 err sticky", 64'(align_err), 64'(1));

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R5 err cleared by reset", 64'(align_err), 64'(0));
    query('{8'd3, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b0}, "R1 R10 after reset");
    @(negedge clk);
    check("R10 idle no valid", 64'(o_valid), 64'(0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule